// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits beside one processor and decides which single interrupt is currently presented to it. It holds the processor's current priority, exactly one pending interrupt (source number and priority) and a software inter-processor interrupt (IPI) priority register. A source unit offers interrupts as a source number with a priority. The controller keeps whichever candidate is more favoured, where a numerically lower priority value is more favoured. Any candidate that loses, or is displaced, is handed back to the source unit as a reject so that it can be offered again later.

The processor side issues one operation per cycle: poll, accept, end-of-interrupt (EOI), current-priority write or IPI-priority write. Accept and poll return the 32-bit status word one cycle later. The status word carries the current priority in bits 31:24 and the pending source number in bits 23:0. A source field of zero means that nothing is pending. The IPI always uses source number 2 and competes for the pending slot in the same way as offers from the source unit.

Toward the source unit the controller emits single-cycle reject, completion and resend pulses. Every effect of an input sampled at a clock edge, whether a state change, a pulse or read data, is visible from that edge onward and lasts until the next edge. Reset is synchronous and active high.

Top module: `intr_presenter`

## Requirements
- R1: While rst is high at a clock edge, the controller returns to its idle state: status word 0, pending priority 0xff, IPI priority 0xff and irq_out low. All pulses and rd_valid are low after that edge.
- R2: A poll (op_code 0) returns, after the edge, rd_word = {current priority[31:24], pending source[23:0]} and rd_ipi = the IPI priority, with rd_valid high for one cycle.
- R3: An accepted offer (offer_valid and offer_ready) is rejected when its priority is greater than or equal to the current priority. It is also rejected when a source is pending whose priority is less than or equal to the offer's. A rejection is a pulse on rej_valid with rej_src equal to the offered source.
- R4: An offer that is not rejected becomes the pending interrupt and sets irq_out. If another source was pending, that source is reported on rej_valid/rej_src in the same cycle. Offers never carry source number 0, and at most one reject is issued per cycle.
- R5: An IPI-priority write (op_code 4, value in op_data[7:0]) whose value is below the current priority runs an IPI check. The check leaves everything unchanged if a pending source has a priority less than or equal to the IPI priority. Otherwise it rejects any pending source, makes source 2 pending at the IPI priority and sets irq_out.
- R6: Accept (op_code 1) returns the old status word on rd_word and lowers irq_out. The pending priority becomes the current priority, the pending source becomes 0 and the pending priority becomes 0xff.
- R7: A current-priority write (op_code 3, value in op_data[7:0]) that lowers the value, while a source is pending with a priority greater than or equal to the new value, clears the pending source, sets the pending priority to 0xff, lowers irq_out and rejects that source.
- R8: A current-priority write that does not lower the value while nothing is pending issues a resend. A resend first runs the IPI check (R5) if the IPI priority is below the current priority, then pulses resend_valid. If something is pending, no resend is issued.
- R9: EOI (op_code 2) loads op_data[31:24] as the current priority and pulses eoi_valid with eoi_src = op_data[23:0]. If nothing is pending afterwards, a resend (R8) follows in the same cycle.
- R10: offer_ready is low in any cycle with op_valid high. An offer presented in such a cycle leaves the state unchanged and must be held by the source unit.
- R11: A poll changes no state: the status word, the IPI priority and irq_out are the same after it, and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Processor operation present this cycle |
| op_code | input | 3 | 0 poll, 1 accept, 2 EOI, 3 current-priority write, 4 IPI-priority write; other codes do nothing |
| op_data | input | 32 | EOI word, or a priority value in bits 7:0 |
| offer_valid | input | 1 | Source unit offers an interrupt |
| offer_src | input | 24 | Offered source number (non-zero) |
| offer_prio | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer is taken this cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| rd_valid | output | 1 | Read data from poll or accept is valid |
| rd_word | output | 32 | Status word returned by poll or accept |
| rd_ipi | output | 8 | IPI priority returned by poll |
| rej_valid | output | 1 | Reject pulse to the source unit |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | Completion pulse to the source unit |
| eoi_src | output | 24 | Completed source number |
| resend_valid | output | 1 | Resend request pulse to the source unit |

## Verification
A processor operation and a source offer can arrive in the same cycle, and an IPI check can also collide with a pending offer. The bench drives a poll together with an offer. It checks that offer_ready is low and that the poll shows the state untouched by the offer. It then holds the offer alone and checks that the offer displaces the pending IPI, with exactly one reject that names source 2. It also runs an EOI whose follow-on resend raises the IPI in the same cycle as the completion pulse, and checks that both pulses and the new pending source appear together.

// File: rtl/intr_pres_pkg.sv
package intr_pres_pkg;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;

    localparam logic [SRC_W-1:0]  IPI_SRC   = SRC_W'(2);
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    typedef enum logic [2:0] {
        OP_POLL    = 3'd0,
        OP_ACCEPT  = 3'd1,
        OP_EOI     = 3'd2,
        OP_SET_CUR = 3'd3,
        OP_SET_IPI = 3'd4
    } pres_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cur_prio;
        logic [SRC_W-1:0]  pend_src;
        logic [PRIO_W-1:0] pend_prio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              irq;
    } pres_state_t;

    typedef struct packed {
        logic              rej;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
        logic              rd;
        logic [WORD_W-1:0] rd_word;
        logic [PRIO_W-1:0] rd_ipi;
    } pres_evt_t;

    typedef struct packed {
        pres_state_t st;
        pres_evt_t   ev;
    } pres_step_t;

    function automatic pres_state_t idle_state();
        pres_state_t s;
        s.cur_prio  = '0;
        s.pend_src  = '0;
        s.pend_prio = PRIO_IDLE;
        s.ipi_prio  = PRIO_IDLE;
        s.irq       = 1'b0;
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(pres_state_t s);
        return {s.cur_prio, s.pend_src};
    endfunction

    // Hand the pending source back to the source unit (single reject slot)
    function automatic pres_step_t bounce_pending(pres_step_t t);
        pres_step_t r = t;
        if (t.st.pend_src != '0) begin
            r.ev.rej     = 1'b1;
            r.ev.rej_src = t.st.pend_src;
        end
        return r;
    endfunction

    function automatic pres_step_t ipi_check(pres_step_t t);
        pres_step_t r = t;
        if (!(t.st.pend_src != '0 && t.st.pend_prio <= t.st.ipi_prio)) begin
            r              = bounce_pending(t);
            r.st.pend_src  = IPI_SRC;
            r.st.pend_prio = t.st.ipi_prio;
            r.st.irq       = 1'b1;
        end
        return r;
    endfunction

    function automatic pres_step_t do_resend(pres_step_t t);
        pres_step_t r = t;
        if (t.st.ipi_prio < t.st.cur_prio)
            r = ipi_check(t);
        r.ev.resend = 1'b1;
        return r;
    endfunction

    function automatic pres_step_t arbitrate_offer(pres_step_t t,
                                                   logic [SRC_W-1:0] src,
                                                   logic [PRIO_W-1:0] prio);
        pres_step_t r = t;
        if (prio >= t.st.cur_prio ||
            (t.st.pend_src != '0 && t.st.pend_prio <= prio)) begin
            r.ev.rej     = 1'b1;
            r.ev.rej_src = src;
        end else begin
            r              = bounce_pending(t);
            r.st.pend_src  = src;
            r.st.pend_prio = prio;
            r.st.irq       = 1'b1;
        end
        return r;
    endfunction

    function automatic pres_step_t write_cur(pres_step_t t, logic [PRIO_W-1:0] v);
        pres_step_t r = t;
        r.st.cur_prio = v;
        if (v < t.st.cur_prio) begin
            if (t.st.pend_src != '0 && v <= t.st.pend_prio) begin
                r              = bounce_pending(r);
                r.st.pend_src  = '0;
                r.st.pend_prio = PRIO_IDLE;
                r.st.irq       = 1'b0;
            end
        end else if (t.st.pend_src == '0) begin
            r = do_resend(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/pres_step_logic.sv
module pres_step_logic
    import intr_pres_pkg::*;
(
    input  pres_state_t       cur,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    input  logic              offer_take,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output pres_step_t        nxt
);

    pres_step_t t;

    always_comb begin
        t.st = cur;
        t.ev = '0;
        if (op_valid) begin
            case (pres_op_e'(op_code))
                OP_POLL: begin
                    t.ev.rd      = 1'b1;
                    t.ev.rd_word = pack_status(cur);
                    t.ev.rd_ipi  = cur.ipi_prio;
                end
                OP_ACCEPT: begin
                    t.ev.rd       = 1'b1;
                    t.ev.rd_word  = pack_status(cur);
                    t.ev.rd_ipi   = cur.ipi_prio;
                    t.st.irq      = 1'b0;
                    t.st.cur_prio = cur.pend_prio;
                    t.st.pend_src = '0;
                    t.st.pend_prio = PRIO_IDLE;
                end
                OP_EOI: begin
                    t.st.cur_prio = op_data[WORD_W-1 -: PRIO_W];
                    t.ev.eoi      = 1'b1;
                    t.ev.eoi_src  = op_data[SRC_W-1:0];
                    if (cur.pend_src == '0)
                        t = do_resend(t);
                end
                OP_SET_CUR: begin
                    t = write_cur(t, op_data[PRIO_W-1:0]);
                end
                OP_SET_IPI: begin
                    t.st.ipi_prio = op_data[PRIO_W-1:0];
                    if (op_data[PRIO_W-1:0] < cur.cur_prio)
                        t = ipi_check(t);
                end
                default: ;
            endcase
        end else if (offer_take) begin
            t = arbitrate_offer(t, offer_src, offer_prio);
        end
    end

    assign nxt = t;

endmodule

// File: rtl/pres_state_reg.sv
module pres_state_reg
    import intr_pres_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pres_state_t d,
    output pres_state_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= idle_state();
        else     q <= d;
    end

endmodule

// File: rtl/pres_event_reg.sv
module pres_event_reg
    import intr_pres_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pres_evt_t d,
    output pres_evt_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
    import intr_pres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              offer_ready,
    output logic              irq_out,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic [PRIO_W-1:0] rd_ipi,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_valid
);

    pres_state_t       state_q;
    pres_step_t        step;
    pres_evt_t         evt_q;
    logic [WORD_W-1:0] status_word;

    // Processor operations win the cycle; the source unit holds its offer
    assign offer_ready = ~op_valid;

    pres_step_logic u_step (
        .cur        (state_q),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_data    (op_data),
        .offer_take (offer_valid & offer_ready),
        .offer_src  (offer_src),
        .offer_prio (offer_prio),
        .nxt        (step)
    );

    pres_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .d   (step.st),
        .q   (state_q)
    );

    pres_event_reg u_evt (
        .clk (clk),
        .rst (rst),
        .d   (step.ev),
        .q   (evt_q)
    );

    assign status_word  = pack_status(state_q);
    assign irq_out      = state_q.irq;
    assign rd_valid     = evt_q.rd;
    assign rd_word      = evt_q.rd_word;
    assign rd_ipi       = evt_q.rd_ipi;
    assign rej_valid    = evt_q.rej;
    assign rej_src      = evt_q.rej_src;
    assign eoi_valid    = evt_q.eoi;
    assign eoi_src      = evt_q.eoi_src;
    assign resend_valid = evt_q.resend;

endmodule

// File: rtl/intr_presenter_chk.sv
module intr_presenter_chk
    import intr_pres_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [WORD_W-1:0] op_data,
    input logic              offer_valid,
    input logic              offer_ready,
    input logic [SRC_W-1:0]  offer_src,
    input logic [PRIO_W-1:0] offer_prio,
    input logic              irq_out,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_word,
    input logic              rej_valid,
    input logic [SRC_W-1:0]  rej_src,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src,
    input logic [WORD_W-1:0] status
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_out && status == '0 && !rej_valid && !rd_valid));

    // R3
    weak_offer_bounced_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && offer_ready && offer_prio >= status[WORD_W-1 -: PRIO_W])
        |=> (rej_valid && rej_src == $past(offer_src)));

    // R4
    irq_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> status[SRC_W-1:0] != '0);

    // R6
    accept_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ACCEPT)
        |=> (!irq_out && rd_valid && rd_word == $past(status)
             && status[SRC_W-1:0] == '0));

    // R9
    eoi_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_EOI)
        |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])
             && status[WORD_W-1 -: PRIO_W] == $past(op_data[WORD_W-1 -: PRIO_W])));

    // R11
    poll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_POLL)
        |=> (rd_word == $past(status) && status == $past(status)
             && irq_out == $past(irq_out) && !rej_valid && !eoi_valid));

endmodule

bind intr_presenter intr_presenter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_data     (op_data),
    .offer_valid (offer_valid),
    .offer_ready (offer_ready),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .irq_out     (irq_out),
    .rd_valid    (rd_valid),
    .rd_word     (rd_word),
    .rej_valid   (rej_valid),
    .rej_src     (rej_src),
    .eoi_valid   (eoi_valid),
    .eoi_src     (eoi_src),
    .status      (status_word)
);

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_ready, irq_out, rd_valid, rej_valid, eoi_valid, resend_valid;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi;
    logic [23:0] rej_src, eoi_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // captured after the edge
    logic        c_rd, c_rej, c_eoi, c_rs, c_irq;
    logic [31:0] c_word;
    logic [7:0]  c_ipi;
    logic [23:0] c_rej_src, c_eoi_src;

    always #10 clk = ~clk;

    intr_presenter u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_ready(offer_ready), .irq_out(irq_out), .rd_valid(rd_valid),
        .rd_word(rd_word), .rd_ipi(rd_ipi), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step_edge();
        @(posedge clk);
        #2;
        c_rd = rd_valid; c_word = rd_word; c_ipi = rd_ipi;
        c_rej = rej_valid; c_rej_src = rej_src;
        c_eoi = eoi_valid; c_eoi_src = eoi_src;
        c_rs = resend_valid; c_irq = irq_out;
        op_valid = 1'b0;
        offer_valid = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] code, input logic [31:0] data);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_data = data;
        step_edge();
    endtask

    task automatic do_offer(input logic [23:0] src, input logic [7:0] prio);
        @(negedge clk);
        offer_valid = 1'b1; offer_src = src; offer_prio = prio;
        step_edge();
    endtask

    task automatic poll_expect(input string req, input logic [31:0] w, input logic [7:0] ipi);
        do_op(3'd0, 32'h0);
        chk(req, {31'b0, c_rd}, 32'd1);
        chk(req, c_word, w);
        chk(req, {24'b0, c_ipi}, {24'b0, ipi});
    endtask

    task automatic t_reset_state();
        poll_expect("R1 R2 idle poll", 32'h0, 8'hff);
        chk("R1 irq low", {31'b0, c_irq}, 32'd0);
    endtask

    task automatic t_offers();
        do_op(3'd3, 32'h10);
        chk("R8 resend on raise", {31'b0, c_rs}, 32'd1);
        chk("R8 no reject", {31'b0, c_rej}, 32'd0);
        do_offer(24'h30, 8'h05);
        chk("R4 taken no reject", {31'b0, c_rej}, 32'd0);
        chk("R4 irq high", {31'b0, c_irq}, 32'd1);
        poll_expect("R2 R4 status", 32'h10000030, 8'hff);
        do_offer(24'h31, 8'h05);
        chk("R3 equal pending prio", {8'b0, c_rej_src}, 32'h31);
        chk("R3 reject pulse", {31'b0, c_rej}, 32'd1);
        do_offer(24'h32, 8'h10);
        chk("R3 not below current", {8'b0, c_rej_src}, 32'h32);
        do_offer(24'h33, 8'h03);
        chk("R4 displaced source", {8'b0, c_rej_src}, 32'h30);
        poll_expect("R4 new pending", 32'h10000033, 8'hff);
    endtask

    task automatic t_accept_eoi();
        do_op(3'd1, 32'h0);
        chk("R6 accept word", c_word, 32'h10000033);
        chk("R6 irq low", {31'b0, c_irq}, 32'd0);
        poll_expect("R6 after accept", 32'h03000000, 8'hff);
        do_op(3'd2, 32'h10000033);
        chk("R9 eoi src", {8'b0, c_eoi_src}, 32'h33);
        chk("R9 eoi pulse", {31'b0, c_eoi}, 32'd1);
        chk("R9 resend", {31'b0, c_rs}, 32'd1);
        poll_expect("R9 after eoi", 32'h10000000, 8'hff);
    endtask

    task automatic t_lower_current();
        do_offer(24'h40, 8'h08);
        do_op(3'd3, 32'h08);
        chk("R7 reject pending", {8'b0, c_rej_src}, 32'h40);
        chk("R7 irq low", {31'b0, c_irq}, 32'd0);
        chk("R7 no resend", {31'b0, c_rs}, 32'd0);
        poll_expect("R7 cleared", 32'h08000000, 8'hff);
    endtask

    task automatic t_ipi();
        do_op(3'd4, 32'h04);
        chk("R5 irq high", {31'b0, c_irq}, 32'd1);
        chk("R5 no reject", {31'b0, c_rej}, 32'd0);
        poll_expect("R5 ipi pending", 32'h08000002, 8'h04);
        do_offer(24'h50, 8'h03);
        chk("R4 ipi displaced", {8'b0, c_rej_src}, 32'h2);
        do_op(3'd4, 32'h06);
        chk("R5 check no change", {31'b0, c_rej}, 32'd0);
        poll_expect("R5 keeps pending", 32'h08000050, 8'h06);
        do_op(3'd1, 32'h0);
        chk("R6 accept word 2", c_word, 32'h08000050);
        do_op(3'd2, 32'h08000050);
        chk("R9 eoi src 2", {8'b0, c_eoi_src}, 32'h50);
        chk("R9 R8 resend", {31'b0, c_rs}, 32'd1);
        chk("R9 R5 ipi raised", {31'b0, c_irq}, 32'd1);
        poll_expect("R9 ipi after eoi", 32'h08000002, 8'h06);
    endtask

    task automatic t_conflict();
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd0; op_data = 32'h0;
        offer_valid = 1'b1; offer_src = 24'h60; offer_prio = 8'h01;
        #1;
        chk("R10 ready low", {31'b0, offer_ready}, 32'd0);
        @(posedge clk);
        #2;
        chk("R10 offer not taken", rd_word, 32'h08000002);
        chk("R10 no reject", {31'b0, rej_valid}, 32'd0);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R10 ready high", {31'b0, offer_ready}, 32'd1);
        step_edge();
        chk("R10 held offer displaces ipi", {8'b0, c_rej_src}, 32'h2);
        poll_expect("R10 pending", 32'h08000060, 8'h06);
    endtask

    task automatic t_poll_quiet();
        do_op(3'd0, 32'h0);
        chk("R11 no reject", {31'b0, c_rej}, 32'd0);
        chk("R11 irq kept", {31'b0, c_irq}, 32'd1);
        poll_expect("R11 state kept", 32'h08000060, 8'h06);
        do_op(3'd3, 32'h20);
        chk("R8 no resend when pending", {31'b0, c_rs}, 32'd0);
        poll_expect("R8 raised current", 32'h20000060, 8'h06);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R1 irq after reset", {31'b0, irq_out}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        poll_expect("R1 state after reset", 32'h0, 8'hff);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        t_reset_state();
        t_offers();
        t_accept_eoi();
        t_lower_current();
        t_ipi();
        t_conflict();
        t_poll_quiet();
        t_reset_again();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule